// File: doc/BRIEF.md
# Two-Color Pixel Serializer

This block turns a pair of 32-bit words into a stream of pixel values on one 8-bit group of a wider output pin bus. One word carries color bytes and the other carries one bit per pixel. In two-color mode each pixel bit picks one of the two lowest color bytes. That byte, gated by a per-pin mask, drives the selected lane for a programmable number of pixel-clock ticks. All timing advances only on a pixel clock enable, which an upstream counter and divider stage supply. Because of this, an alternating pixel pattern produces a square wave at half the pixel rate.

A writer hands over a colors/pixels pair through a valid/ready handshake into a single pending slot. The running frame lasts a programmable number of pixel ticks. When it ends, the pending pair becomes the active one and the slot frees up. A writer that offers a second pair mid-frame is stalled until that moment. If nothing is pending when a frame ends, the previous pair plays again. Software enables the pins, then sets the mode, lane select and mask, then the scale fields, and only then starts the pixel clock enable.

Top module: `vid_serializer`

## Requirements
- R1: While `mode_on` is 0, `pins` is all zero, `ld_ready` is 1, and a load offered in that state is discarded: after the mode is switched on with nothing pending, `pins` stays 0.
- R2: A pixel bit of 0 outputs colors bits [7:0]; a pixel bit of 1 outputs colors bits [15:8].
- R3: Pixel bits are used least-significant first. Bit k is shown during pixel ticks k*P to k*P+P-1 of a frame, where P is the clocks-per-pixel field.
- R4: A frame lasts F pixel ticks, where F is the clocks-per-frame field. The tick after that starts a new frame from pixel bit 0.
- R5: A clocks-per-pixel field of 0 means 256 ticks, and a clocks-per-frame field of 0 means 4096 ticks.
- R6: With the pending slot full, `ld_ready` is 0 until the frame-end tick. That tick moves the pending pair to the output and raises `ld_ready`.
- R7: When a frame ends with nothing pending, the same colors/pixels pair is played again from bit 0.
- R8: The byte appears on `pins[8*g+7:8*g]` for lane select g, gated bitwise by `pin_mask`. All other pins are 0.
- R9: Counters and output change only on cycles where `pix_ce` is 1.
- R10: Past bit 31 in a frame longer than 32*P ticks, the output shows colors bits [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_ce | input | 1 | Pixel clock enable from the divider stage |
| mode_on | input | 1 | Two-color mode enable; 0 turns the block off |
| grp_sel | input | 2 | Output lane (pin group) select |
| pin_mask | input | 8 | Per-pin drive mask within the lane |
| px_clocks | input | 8 | Pixel ticks per pixel, 0 = 256 |
| fr_clocks | input | 12 | Pixel ticks per frame, 0 = 4096 |
| ld_valid | input | 1 | Writer offers a pair |
| ld_colors | input | 32 | Colors word of the offered pair |
| ld_pixels | input | 32 | Pixels word of the offered pair |
| ld_ready | output | 1 | Pending slot can take a pair |
| pins | output | 32 | Video pin bus, four 8-bit lanes |

## Verification
A handshake can land on the same edge as a frame end. This happens when the pending slot is empty and the writer raises `ld_valid` in the cycle just before the last tick of a frame. In that case the frame must repeat the old pair, and the new pair must be held until the following frame end. The bench provokes this collision on purpose. It then checks the output on the tick after the collision and on the first tick of the next frame. It also forces the stall case, where a full slot and a frame end meet, by watching `ld_ready` tick by tick through a whole frame.

// File: rtl/vid_pkg.sv
// Shared types for the pixel serializer.
// Assumes 32-bit colors and pixels words.
package vid_pkg;
    localparam int WORD_W = 32;

    typedef struct packed {
        logic [WORD_W-1:0] colors;
        logic [WORD_W-1:0] pixels;
    } vid_pair_t;
endpackage

// File: rtl/vid_scale_timer.sv
// Pixel and frame tick counters.
// Both counters count down on pix_ce and reload from the scale fields.
// A field value of zero means the full count (2**width).
// While disabled, both counters sit at 1, so the first enabled tick is a frame end.
module vid_scale_timer #(
    parameter int PPX_W = 8,
    parameter int PFR_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ce,
    input  logic [PPX_W-1:0] ppx,
    input  logic [PFR_W-1:0] pfr,
    output logic             frame_end,
    output logic             px_step
);
    localparam int PC_W = PPX_W + 1;
    localparam int FC_W = PFR_W + 1;

    logic [PC_W-1:0] px_cnt;
    logic [FC_W-1:0] fr_cnt;
    logic [PC_W-1:0] ppx_eff;
    logic [FC_W-1:0] pfr_eff;

    // Map a zero field to the full count.
    always_comb begin
        ppx_eff = (ppx == '0) ? PC_W'(1) << PPX_W : {1'b0, ppx};
        pfr_eff = (pfr == '0) ? FC_W'(1) << PFR_W : {1'b0, pfr};
    end

    // Decode tick events from the current counts.
    always_comb begin
        frame_end = en && ce && (fr_cnt == FC_W'(1));
        px_step   = en && ce && !frame_end && (px_cnt == PC_W'(1));
    end

    // Count down per tick and reload on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            px_cnt <= PC_W'(1);
            fr_cnt <= FC_W'(1);
        end else if (ce) begin
            if (frame_end) begin
                px_cnt <= ppx_eff;
                fr_cnt <= pfr_eff;
            end else begin
                fr_cnt <= fr_cnt - FC_W'(1);
                px_cnt <= (px_cnt == PC_W'(1)) ? ppx_eff : px_cnt - PC_W'(1);
            end
        end
    end

    p_px_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (px_cnt != '0));

    p_frame_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (!en || fr_cnt == $past(pfr_eff)));
endmodule

// File: rtl/vid_load_buffer.sv
// Single pending slot behind a valid/ready handshake.
// The slot takes a pair when it is empty.
// The frame-end pulse (take) empties it.
// While disabled, the slot is cleared, ready is held high and offers are dropped.
module vid_load_buffer
    import vid_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      ld_valid,
    input  vid_pair_t ld_pair,
    output logic      ld_ready,
    input  logic      take,
    output logic      pend_full,
    output vid_pair_t pend_pair
);
    logic accept;

    // Ready when off or when the slot is free.
    always_comb begin
        ld_ready = !en || !pend_full;
        accept   = en && ld_valid && !pend_full;
    end

    // Fill on handshake, drain on frame end.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pend_full <= 1'b0;
        end else if (accept) begin
            pend_full <= 1'b1;
        end else if (take) begin
            pend_full <= 1'b0;
        end
    end

    // Capture the offered pair on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_pair <= '0;
        end else if (accept) begin
            pend_pair <= ld_pair;
        end
    end

    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && pend_full && !take) |=> $stable(pend_pair));

    p_ready_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> ld_ready);
endmodule

// File: rtl/vid_pixel_shifter.sv
// Holds the active pair and shifts pixel bits out LSB first.
// Selects one of two color bytes per pixel and places it on a pin lane under the mask.
// On a frame end it loads the pending pair, or replays the saved pixels if nothing is pending.
module vid_pixel_shifter
    import vid_pkg::*;
#(
    parameter int GROUPS = 4,
    parameter int LANE_W = 8,
    parameter int GSEL_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     frame_end,
    input  logic                     px_step,
    input  logic                     pend_full,
    input  vid_pair_t                pend_pair,
    input  logic [GSEL_W-1:0]        grp,
    input  logic [LANE_W-1:0]        mask,
    output logic [GROUPS*LANE_W-1:0] pins
);
    logic [WORD_W-1:0] colors_q;
    logic [WORD_W-1:0] saved_q;
    logic [WORD_W-1:0] shreg_q;
    logic [LANE_W-1:0] lane_val;

    // Load a new or repeated frame, else shift per pixel.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            colors_q <= '0;
            saved_q  <= '0;
            shreg_q  <= '0;
        end else if (frame_end) begin
            if (pend_full) begin
                colors_q <= pend_pair.colors;
                saved_q  <= pend_pair.pixels;
                shreg_q  <= pend_pair.pixels;
            end else begin
                shreg_q  <= saved_q;
            end
        end else if (px_step) begin
            shreg_q <= shreg_q >> 1;
        end
    end

    // Two-color pick gated by the pin mask.
    always_comb begin
        lane_val = (shreg_q[0] ? colors_q[2*LANE_W-1:LANE_W] : colors_q[LANE_W-1:0]) & mask;
    end

    // Route the lane value to the selected group only.
    for (genvar g = 0; g < GROUPS; g++) begin : g_lane
        assign pins[g*LANE_W +: LANE_W] = (en && grp == GSEL_W'(g)) ? lane_val : '0;
    end

    p_off_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (pins == '0));

    p_shift_lsb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        px_step |=> (!en || shreg_q == ($past(shreg_q) >> 1)));

    p_repeat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !pend_full) |=> (!en || shreg_q == $past(saved_q)));

    p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pins) <= $countones(mask));
endmodule

// File: rtl/vid_serializer.sv
// Two-color pixel serializer top.
// Connects the scale timer, the pending-pair buffer and the pixel shifter.
// Assumes pix_ce comes from an upstream clock divider stage.
module vid_serializer
    import vid_pkg::*;
#(
    parameter int GROUPS = 4,
    parameter int LANE_W = 8,
    parameter int PPX_W  = 8,
    parameter int PFR_W  = 12,
    localparam int GSEL_W = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int PINS_W = GROUPS * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_ce,
    input  logic              mode_on,
    input  logic [GSEL_W-1:0] grp_sel,
    input  logic [LANE_W-1:0] pin_mask,
    input  logic [PPX_W-1:0]  px_clocks,
    input  logic [PFR_W-1:0]  fr_clocks,
    input  logic              ld_valid,
    input  logic [WORD_W-1:0] ld_colors,
    input  logic [WORD_W-1:0] ld_pixels,
    output logic              ld_ready,
    output logic [PINS_W-1:0] pins
);
    logic      frame_end;
    logic      px_step;
    logic      pend_full;
    vid_pair_t pend_pair;
    vid_pair_t in_pair;

    // Pack the offered words into one pair.
    always_comb begin
        in_pair.colors = ld_colors;
        in_pair.pixels = ld_pixels;
    end

    vid_scale_timer #(.PPX_W(PPX_W), .PFR_W(PFR_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (mode_on),
        .ce        (pix_ce),
        .ppx       (px_clocks),
        .pfr       (fr_clocks),
        .frame_end (frame_end),
        .px_step   (px_step)
    );

    vid_load_buffer u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (mode_on),
        .ld_valid  (ld_valid),
        .ld_pair   (in_pair),
        .ld_ready  (ld_ready),
        .take      (frame_end),
        .pend_full (pend_full),
        .pend_pair (pend_pair)
    );

    vid_pixel_shifter #(.GROUPS(GROUPS), .LANE_W(LANE_W), .GSEL_W(GSEL_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (mode_on),
        .frame_end (frame_end),
        .px_step   (px_step),
        .pend_full (pend_full),
        .pend_pair (pend_pair),
        .grp       (grp_sel),
        .mask      (pin_mask),
        .pins      (pins)
    );

    p_ce_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_ce && mode_on && $past(mode_on)) |=> (!mode_on || $stable(pins) || $changed(grp_sel) || $changed(pin_mask)));
endmodule

// File: tb/vid_serializer_tb.sv
module vid_serializer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_ce = 1'b0;
    logic        mode_on = 1'b0;
    logic [1:0]  grp_sel = '0;
    logic [7:0]  pin_mask = '0;
    logic [7:0]  px_clocks = 8'd1;
    logic [11:0] fr_clocks = 12'd32;
    logic        ld_valid = 1'b0;
    logic [31:0] ld_colors = '0;
    logic [31:0] ld_pixels = '0;
    logic        ld_ready;
    logic [31:0] pins;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vid_serializer u_dut (
        .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .mode_on(mode_on),
        .grp_sel(grp_sel), .pin_mask(pin_mask), .px_clocks(px_clocks),
        .fr_clocks(fr_clocks), .ld_valid(ld_valid), .ld_colors(ld_colors),
        .ld_pixels(ld_pixels), .ld_ready(ld_ready), .pins(pins)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_pins(input logic [31:0] col, input logic [31:0] pix,
                                             input int ppx_e, input int grp,
                                             input logic [7:0] mask, input int j);
        int b;
        logic bv;
        logic [7:0] by;
        b  = j / ppx_e;
        bv = (b < 32) ? pix[b] : 1'b0;
        by = bv ? col[15:8] : col[7:0];
        return 32'(by & mask) << (8 * grp);
    endfunction

    // Switch off, configure, switch on and place one pair in the pending slot.
    task automatic setup(input int grp, input logic [7:0] mask, input logic [7:0] ppx,
                         input logic [11:0] pfr, input logic [31:0] col, input logic [31:0] pix);
        @(negedge clk);
        mode_on = 1'b0; pix_ce = 1'b0; ld_valid = 1'b0;
        @(negedge clk);
        grp_sel = 2'(grp); pin_mask = mask; px_clocks = ppx; fr_clocks = pfr;
        mode_on = 1'b1;
        ld_valid = 1'b1; ld_colors = col; ld_pixels = pix;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    // Run edges ticks with pix_ce on every div-th cycle and check each sample.
    task automatic play(input logic [31:0] col, input logic [31:0] pix, input int ppx_e,
                        input int pfr_e, input int grp, input logic [7:0] mask,
                        input int edges, input int div);
        int cnt = 0;
        int t = 0;
        while (cnt < edges) begin
            pix_ce = ((t % div) == 0);
            t++;
            @(negedge clk);
            if (pix_ce) cnt++;
            if (cnt > 0) begin
                logic [31:0] e;
                e = exp_pins(col, pix, ppx_e, grp, mask, (cnt - 1) % pfr_e);
                // R2 R3 R4 R7 R8 R9 R10: pixel bit order, frame length, repeat, lane and mask
                chk(pins === e, "R2/R3/R4/R7/R8/R9/R10", pins, e);
            end
        end
        pix_ce = 1'b0;
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int idx = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state with mode off
        chk(pins === 32'd0, "R1 reset pins", pins, 32'd0);
        chk(ld_ready === 1'b1, "R1 reset ready", 32'(ld_ready), 32'd1);

        // R1: an offer while off is dropped
        pin_mask = 8'hFF; px_clocks = 8'd1; fr_clocks = 12'd8;
        ld_valid = 1'b1; ld_colors = 32'hFFFF_FF00; ld_pixels = 32'h5555_5555;
        @(negedge clk);
        chk(ld_ready === 1'b1, "R1 off ready", 32'(ld_ready), 32'd1);
        chk(pins === 32'd0, "R1 off pins", pins, 32'd0);
        ld_valid = 1'b0;
        mode_on = 1'b1; pix_ce = 1'b1;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            chk(pins === 32'd0, "R1 dropped load", pins, 32'd0);
        end
        pix_ce = 1'b0;

        // R2: alternating pattern gives a square wave between the two color bytes
        setup(0, 8'hFF, 8'd1, 12'd32, 32'hFFFF_FF00, 32'h5555_5555);
        play(32'hFFFF_FF00, 32'h5555_5555, 1, 32, 0, 8'hFF, 64, 1);

        // Sweep pixel width, frame length, clock-enable spacing, lane and mask
        for (int p = 1; p <= 3; p++) begin
            for (int fi = 0; fi < 4; fi++) begin
                for (int div = 1; div <= 2; div++) begin
                    int f;
                    logic [31:0] col;
                    logic [31:0] pix;
                    logic [7:0] m;
                    f   = (fi == 0) ? 7 : (fi == 1) ? 32 : (fi == 2) ? 50 : 100;
                    col = {16'hA5C3, 8'(idx * 37 + 11), 8'(idx * 53 + 200)};
                    pix = 32'h9E37_79B9 * (idx + 1);
                    m   = (idx % 3 == 0) ? 8'hFF : 8'(idx * 29 + 5);
                    setup(idx % 4, m, 8'(p), 12'(f), col, pix);
                    play(col, pix, p, f, idx % 4, m, 2 * f, div);
                    idx++;
                end
            end
        end

        // R5: zero clocks-per-pixel means 256
        setup(2, 8'hF0, 8'd0, 12'd600, 32'h0000_3CC3, 32'h0000_0005);
        play(32'h0000_3CC3, 32'h0000_0005, 256, 600, 2, 8'hF0, 600, 1);
        // R5: zero clocks-per-frame means 4096
        setup(3, 8'hFF, 8'd200, 12'd0, 32'h0000_81E7, 32'h0001_2345);
        play(32'h0000_81E7, 32'h0001_2345, 200, 4096, 3, 8'hFF, 4096 + 300, 1);

        // R6: stall while the pending slot is full
        setup(1, 8'hFF, 8'd1, 12'd40, 32'h0000_1122, 32'hF0F0_1234);
        pix_ce = 1'b1;
        ld_valid = 1'b1; ld_colors = 32'h0000_3344; ld_pixels = 32'h0F0F_8001;
        @(negedge clk);
        chk(pins === exp_pins(32'h0000_1122, 32'hF0F0_1234, 1, 1, 8'hFF, 0), "R6 first frame",
            pins, exp_pins(32'h0000_1122, 32'hF0F0_1234, 1, 1, 8'hFF, 0));
        chk(ld_ready === 1'b1, "R6 slot freed", 32'(ld_ready), 32'd1);
        @(negedge clk);
        chk(ld_ready === 1'b0, "R6 stall", 32'(ld_ready), 32'd0);
        ld_colors = 32'h0000_5566; ld_pixels = 32'hAAAA_0003;
        for (int k = 2; k < 40; k++) begin
            @(negedge clk);
            chk(ld_ready === 1'b0, "R6 stall mid-frame", 32'(ld_ready), 32'd0);
            chk(pins === exp_pins(32'h0000_1122, 32'hF0F0_1234, 1, 1, 8'hFF, k), "R6 frame A",
                pins, exp_pins(32'h0000_1122, 32'hF0F0_1234, 1, 1, 8'hFF, k));
        end
        @(negedge clk);
        chk(ld_ready === 1'b1, "R6 release at frame end", 32'(ld_ready), 32'd1);
        chk(pins === exp_pins(32'h0000_3344, 32'h0F0F_8001, 1, 1, 8'hFF, 0), "R6 frame B",
            pins, exp_pins(32'h0000_3344, 32'h0F0F_8001, 1, 1, 8'hFF, 0));
        @(negedge clk);
        ld_valid = 1'b0;
        for (int k = 2; k < 41; k++) @(negedge clk);
        chk(pins === exp_pins(32'h0000_5566, 32'hAAAA_0003, 1, 1, 8'hFF, 0), "R6 frame C",
            pins, exp_pins(32'h0000_5566, 32'hAAAA_0003, 1, 1, 8'hFF, 0));
        pix_ce = 1'b0;

        // R7: handshake on the frame-end edge; the old pair repeats first
        setup(0, 8'hFF, 8'd2, 12'd20, 32'h0000_7E18, 32'h0000_0006);
        pix_ce = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk(pins === exp_pins(32'h0000_7E18, 32'h0000_0006, 2, 0, 8'hFF, k), "R7 frame A",
                pins, exp_pins(32'h0000_7E18, 32'h0000_0006, 2, 0, 8'hFF, k));
        end
        ld_valid = 1'b1; ld_colors = 32'h0000_C30F; ld_pixels = 32'h0000_0001;
        @(negedge clk);
        ld_valid = 1'b0;
        chk(pins === exp_pins(32'h0000_7E18, 32'h0000_0006, 2, 0, 8'hFF, 0), "R7 collision repeat",
            pins, exp_pins(32'h0000_7E18, 32'h0000_0006, 2, 0, 8'hFF, 0));
        chk(ld_ready === 1'b0, "R6 collision slot full", 32'(ld_ready), 32'd0);
        for (int k = 0; k < 20; k++) @(negedge clk);
        chk(pins === exp_pins(32'h0000_C30F, 32'h0000_0001, 2, 0, 8'hFF, 0), "R7 pending shown",
            pins, exp_pins(32'h0000_C30F, 32'h0000_0001, 2, 0, 8'hFF, 0));
        pix_ce = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule